// File: doc/BRIEF.md
# TDM Slot Pseudo-Random Sequence Checker

This block watches one serial stream of a time-division multiplexed link and counts bit errors in a run of consecutive channels that a far-end generator fills with a 2^15-1 pseudo-random sequence. A frame pulse marks bit 0 of each frame. The block keeps a bit position counter from that pulse and decodes a comparison window from a first channel and a channel count. Inside that window each received bit is checked against a locally predicted sequence bit.

When the run enable rises, the checker uses the first fifteen window bits to fill its shift register from the line. After that it predicts every following bit on its own and carries its state across frames. Each mismatch adds one to a 16-bit error count. The count stops at its maximum value and stays there until software clears it. Software raises the enable together with the generator. It waits a couple of frames plus the loop delay, then pulses the clear input to start a clean count.

Top module: `tdm_prbs_checker`

## Requirements
- R1: After reset, `err_count` reads 0.
- R2: Only the bits at frame positions `start_chan*8` through `start_chan*8 + win_len*8 - 1` are compared. Position 0 is the cycle in which `frame_sync` is high, and each channel is 8 bits. Bits outside this window never change the count.
- R3: Only the input lane `rx_data[start_stream]` is compared. The other lanes have no effect on the count.
- R4: The sequence follows the rule next bit = s[14] XOR s[13], and the bit is shifted into s[0]. After `run_en` rises, the first 15 window bits load the shift register and are never counted.
- R5: After lock, every window bit that differs from the predicted bit adds exactly one to `err_count`. The count is exact over any number of frames.
- R6: `err_count` stops at 16'hFFFF and does not wrap while errors continue.
- R7: While `clr_cnt` is high, `err_count` is held at 0. Clear wins over a coincident error.
- R8: While `run_en` is low, the count holds its value whatever the data. A later rise of `run_en` makes the checker re-lock to a new sequence phase.
- R9: The bit position restarts at 0 on each `frame_sync`. The predictor keeps its phase across frame boundaries, so a clean multi-frame run counts no errors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| frame_sync | input | 1 | High during bit 0 of a frame |
| rx_data | input | NUM_STREAMS (4) | Serial input lanes, one bit per clock each |
| start_stream | input | 2 | Lane to compare |
| start_chan | input | 5 | First channel of the comparison window |
| win_len | input | 6 | Number of consecutive channels compared |
| run_en | input | 1 | Starts and stops the checker |
| clr_cnt | input | 1 | Holds the error count at zero while high |
| err_count | output | 16 | Saturating bit error count |

## Verification
The bench sends a looped-back sequence with a known number of flipped bits through windows at the first channel, the last channel, and across the whole frame. It uses every lane, and puts inverted data on the lanes that are not selected and noise outside the window. A design that decodes the window off by one channel, picks the wrong lane, or counts seed bits would show a nonzero count on clean runs or a count that differs from the number of injected errors. A design that re-synchronises from the line after lock would multiply the errors. An inverted-data run counts a known 256 errors per frame and is then driven past 65535, where a wrapping counter would read small again. Clearing during errors, and sending garbage while disabled, check that clear has priority and that a stopped checker holds its count and re-locks.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;

    // length of the pseudo-random shift register
    localparam int PRBS_LEN = 15;
    // feedback taps, x^15 + x^14 + 1
    localparam int TAP_HI   = 14;
    localparam int TAP_LO   = 13;

    function automatic logic prbs_next(input logic [PRBS_LEN-1:0] s);
        return s[TAP_HI] ^ s[TAP_LO];
    endfunction

endpackage

// File: rtl/tdm_bitpos.sv
module tdm_bitpos #(
    parameter int FRAME_BITS = 256,
    localparam int PW        = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic [PW-1:0] pos_now
);

    typedef struct packed {
        logic [PW-1:0] pos;
    } pos_st_t;

    pos_st_t st_q, st_d;

    // position of the bit present on the line in this cycle
    always_comb begin
        st_d = st_q;
        if (frame_sync) begin
            st_d.pos = '0;
        end else if (st_q.pos == PW'(FRAME_BITS - 1)) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + PW'(1);
        end
        pos_now = st_d.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= PW'(FRAME_BITS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R9: the register follows the frame pulse one cycle later
    a_r9_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (st_q.pos == '0));

endmodule

// File: rtl/slot_window.sv
module slot_window #(
    parameter int CHANNELS   = 32,
    parameter int CH_BITS    = 8,
    localparam int FRAME_BITS = CHANNELS * CH_BITS,
    localparam int PW        = $clog2(FRAME_BITS),
    localparam int CW        = $clog2(CHANNELS),
    localparam int LW        = CW + 1,
    localparam int EW        = PW + 2
) (
    input  logic [PW-1:0] pos,
    input  logic [CW-1:0] start_chan,
    input  logic [LW-1:0] win_len,
    output logic          in_win
);

    localparam logic [EW-1:0] CHB = EW'(CH_BITS);

    logic [EW-1:0] lo_bit;
    logic [EW-1:0] hi_bit;
    logic [EW-1:0] pos_ext;

    always_comb begin
        lo_bit  = EW'(start_chan) * CHB;
        hi_bit  = lo_bit + (EW'(win_len) * CHB);
        pos_ext = EW'(pos);
        in_win  = (pos_ext >= lo_bit) && (pos_ext < hi_bit);
    end

endmodule

// File: rtl/prbs_track.sv
module prbs_track
    import tdm_prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic in_win,
    input  logic rx_bit,
    output logic locked,
    output logic mismatch
);

    localparam int SCW = $clog2(PRBS_LEN + 1);

    typedef struct packed {
        logic [PRBS_LEN-1:0] shreg;
        logic [SCW-1:0]      fill;
    } trk_st_t;

    trk_st_t st_q, st_d;
    logic    pred;

    always_comb begin
        st_d     = st_q;
        pred     = prbs_next(st_q.shreg);
        locked   = (st_q.fill == SCW'(PRBS_LEN));
        mismatch = run && in_win && locked && (rx_bit != pred);
        if (!run) begin
            st_d.fill = '0;
        end else if (in_win) begin
            if (!locked) begin
                // seed phase: take the line bits as they come
                st_d.shreg = {st_q.shreg[PRBS_LEN-2:0], rx_bit};
                st_d.fill  = st_q.fill + SCW'(1);
            end else begin
                // free-running prediction, immune to line errors
                st_d.shreg = {st_q.shreg[PRBS_LEN-2:0], pred};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.fill  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: stopping drops lock so the next start re-seeds
    a_r8_stop_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !locked);

    // R4: once locked, lock holds while running
    a_r4_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && locked) |=> locked);

    // R4: seed bits are never flagged
    a_r4_seed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (run && in_win && $past(!run)) |-> !mismatch);

endmodule

// File: rtl/sat_err_cnt.sv
module sat_err_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (hit && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: once at the top, stay at the top until cleared
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == CNT_MAX) && !clr) |=> (count == CNT_MAX));

    // R7: clear forces zero on the next cycle
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R5: the count grows by at most one per bit
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

endmodule

// File: rtl/tdm_prbs_checker.sv
module tdm_prbs_checker #(
    parameter int NUM_STREAMS = 4,
    parameter int CHANNELS    = 32,
    parameter int CH_BITS     = 8,
    parameter int CNT_W       = 16,
    localparam int SW         = $clog2(NUM_STREAMS),
    localparam int CW         = $clog2(CHANNELS),
    localparam int LW         = CW + 1,
    localparam int FRAME_BITS = CHANNELS * CH_BITS,
    localparam int PW         = $clog2(FRAME_BITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_sync,
    input  logic [NUM_STREAMS-1:0] rx_data,
    input  logic [SW-1:0]          start_stream,
    input  logic [CW-1:0]          start_chan,
    input  logic [LW-1:0]          win_len,
    input  logic                   run_en,
    input  logic                   clr_cnt,
    output logic [CNT_W-1:0]       err_count
);

    logic [PW-1:0] pos_now;
    logic          in_win;
    logic          rx_bit;
    logic          locked;
    logic          mismatch;

    tdm_bitpos #(
        .FRAME_BITS (FRAME_BITS)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .pos_now    (pos_now)
    );

    slot_window #(
        .CHANNELS (CHANNELS),
        .CH_BITS  (CH_BITS)
    ) u_win (
        .pos        (pos_now),
        .start_chan (start_chan),
        .win_len    (win_len),
        .in_win     (in_win)
    );

    always_comb begin
        rx_bit = rx_data[start_stream];
    end

    prbs_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .in_win   (in_win),
        .rx_bit   (rx_bit),
        .locked   (locked),
        .mismatch (mismatch)
    );

    sat_err_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .hit   (mismatch),
        .count (err_count)
    );

    // R2: bits outside the window leave the count alone
    a_r2_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win && !clr_cnt) |=> $stable(err_count));

    // R8: a stopped checker holds its count
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr_cnt) |=> $stable(err_count));

    // R4: no count while still seeding
    a_r4_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clr_cnt) |=> $stable(err_count));

endmodule

// File: tb/sim_tdm_prbs_checker.sv
module sim_tdm_prbs_checker;

    localparam int NS = 4;
    localparam int FB = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic [NS-1:0] rx_data = '0;
    logic [1:0]    start_stream = '0;
    logic [4:0]    start_chan = '0;
    logic [5:0]    win_len = 6'd1;
    logic          run_en = 1'b0;
    logic          clr_cnt = 1'b0;
    logic [15:0]   err_count;

    int n_run = 0;
    int n_fail = 0;

    // bench-side generator and error injection state
    logic [14:0] gs = 15'h7FFF;
    int g_idx = 0;
    int inj_gap = 1;
    int inj_left = 0;
    bit flip_all = 1'b0;

    always #10 clk = ~clk;

    tdm_prbs_checker u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .rx_data      (rx_data),
        .start_stream (start_stream),
        .start_chan   (start_chan),
        .win_len      (win_len),
        .run_en       (run_en),
        .clr_cnt      (clr_cnt),
        .err_count    (err_count)
    );

    // stream, start, len, errors, gap, frames
    localparam logic [47:0] VEC [0:6] = '{
        {8'd0, 8'd0,  8'd1,  8'd0,   8'd1, 8'd3},
        {8'd1, 8'd4,  8'd2,  8'd5,   8'd7, 8'd3},
        {8'd2, 8'd10, 8'd4,  8'd12,  8'd3, 8'd2},
        {8'd3, 8'd31, 8'd1,  8'd3,   8'd4, 8'd4},
        {8'd0, 8'd0,  8'd32, 8'd200, 8'd1, 8'd2},
        {8'd3, 8'd16, 8'd16, 8'd1,   8'd1, 8'd1},
        {8'd1, 8'd20, 8'd3,  8'd9,   8'd5, 8'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // caller sits at a negedge; drives nf whole frames
    task automatic frames(input int nf);
        for (int f = 0; f < nf; f++) begin
            for (int p = 0; p < FB; p++) begin
                int  lo;
                int  hi;
                bit  b;
                bit  win;
                lo  = int'(start_chan) * 8;
                hi  = lo + int'(win_len) * 8;
                win = (p >= lo) && (p < hi);
                frame_sync = (p == 0);
                if (win && run_en) begin
                    b  = gs[14] ^ gs[13];
                    gs = {gs[13:0], b};
                    if (g_idx >= 15) begin
                        if (flip_all) begin
                            b = ~b;
                        end else if (inj_left > 0 && ((g_idx - 15) % inj_gap) == 0) begin
                            b = ~b;
                            inj_left--;
                        end
                    end
                    g_idx++;
                    for (int s = 0; s < NS; s++) rx_data[s] = ~b;
                    rx_data[start_stream] = b;
                end else begin
                    for (int s = 0; s < NS; s++) rx_data[s] = p[0] ^ p[2] ^ s[0];
                end
                @(negedge clk);
            end
        end
        frame_sync = 1'b0;
    endtask

    task automatic start_gen(input logic [14:0] seed);
        gs    = seed;
        g_idx = 0;
        run_en = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset release", int'(err_count), 0);

        // table of windows, lanes and injected errors (R2 R3 R4 R5 R9)
        for (int v = 0; v < 7; v++) begin
            logic [47:0] e;
            e = VEC[v];
            run_en       = 1'b0;
            flip_all     = 1'b0;
            start_stream = e[41:40];
            start_chan   = e[36:32];
            win_len      = e[29:24];
            clr_cnt      = 1'b1;
            frames(1);
            clr_cnt  = 1'b0;
            inj_left = int'(e[23:16]);
            inj_gap  = int'(e[15:8]);
            start_gen(15'h7FFF ^ 15'(v * 911));
            frames(int'(e[7:0]));
            chk($sformatf("R5 R2 R3 vector %0d exact count", v), int'(err_count), int'(e[23:16]));
        end

        // R8: stop, feed garbage, count holds
        run_en = 1'b0;
        frames(2);
        chk("R8 count held while stopped", int'(err_count), 9);
        // R8 R4: restart on a new phase, must re-lock cleanly
        inj_left = 0;
        start_gen(15'h1234);
        frames(3);
        chk("R8 R4 re-lock after restart", int'(err_count), 9);

        // R7: clear beats errors on every bit
        start_stream = 2'd2;
        start_chan   = 5'd0;
        win_len      = 6'd32;
        run_en       = 1'b0;
        frames(1);
        start_gen(15'h0F0F);
        frames(1);
        flip_all = 1'b1;
        clr_cnt  = 1'b1;
        frames(1);
        chk("R7 clear holds zero under errors", int'(err_count), 0);
        clr_cnt = 1'b0;
        frames(1);
        chk("R5 full inverted frame", int'(err_count), 256);

        // R6: drive past the top
        frames(255);
        chk("R6 saturates at 65535", int'(err_count), 65535);
        frames(2);
        chk("R6 no wrap after more errors", int'(err_count), 65535);
        clr_cnt = 1'b1;
        @(negedge clk);
        chk("R7 clear from saturation", int'(err_count), 0);
        clr_cnt  = 1'b0;
        flip_all = 1'b0;
        run_en   = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule